// File: doc/BRIEF.md
# Floating-Point Maximum with Conditional Move Unit

This block is a single-cycle execution unit wrapped around a bank of eight 32-bit single-precision registers. It accepts one 32-bit instruction word per cycle under a valid strobe. The word names four register indices: a primary target `a`, a challenger `b`, a secondary target `c` and a secondary source `d`. When the value in `a` orders below the value in `b`, the unit overwrites `a` with the value of `b` and, on the same clock edge, copies `d` into `c`. Otherwise both registers keep their contents. The value written into `a` is cleaned first: any NaN pattern becomes an infinity of the same sign, and any subnormal pattern becomes positive zero.

Two status flags, zero and negative, report the outcome of the comparison itself, not the value that ends up in `a`. An instruction whose primary and secondary targets are the same register is refused. It raises an error output and writes nothing.

A preload write port and a registered read port give a test environment or a host direct access to the bank. The comparison works on the raw encodings, with the sign handled explicitly. It is not an IEEE comparator.

Top module: `fmax_move_unit`

## Requirements
- R1: A synchronous active-high `rst` clears all eight registers, `zero_flag`, `neg_flag`, `illegal_op` and `rd_data` to zero at the next rising edge.
- R2: An instruction is decoded only when `instr_valid` is 1, `instr_word[15:0]` equals 16'hE69C and `instr_word[31:28]` is zero. Any other word leaves the registers, both flags and `illegal_op` (held at 0) unchanged.
- R3: The field layout is a = `instr_word[18:16]`, b = `[21:19]`, c = `[24:22]`, d = `[27:25]`. A decoded instruction with a equal to c drives `illegal_op` to 1 in the next cycle and writes no register and no flag. `illegal_op` is 0 after every other cycle.
- R4: Ordering is sign-aware on the raw pattern. Any value with sign bit 0 is above any value with sign bit 1, so -0 orders below +0. Two values with sign 0 order by their low 31 bits as unsigned numbers. Two values with sign 1 order by their low 31 bits reversed. Equality means identical bit patterns.
- R5: When a orders below b, the edge writes the cleaned value of b into a and the value of d (as read before that edge) into c. Otherwise no register changes.
- R6: A NaN written into a (exponent all ones, mantissa nonzero) is stored with the same sign, exponent all ones and mantissa zero.
- R7: A subnormal written into a (exponent zero, mantissa nonzero), of either sign, is stored as 32'h00000000.
- R8: After a legal decoded instruction, the flags show the comparison result. Equal gives zero_flag=1 and neg_flag=0. a above b gives 0 and 0. a below b gives 0 and 1. The flags keep their value when no legal instruction is decoded.
- R9: When `pl_we` is 1 and `instr_valid` is 0, `pl_data` is written into register `pl_idx`. When `instr_valid` is 1, the preload is ignored.
- R10: `rd_data` is registered. After each edge it holds the content of register `rd_idx` as it stood before that edge's writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid | input | 1 | Instruction word is present this cycle |
| instr_word | input | 32 | Instruction: fields in upper half, opcode in lower half |
| pl_we | input | 1 | Preload write enable |
| pl_idx | input | 3 | Preload register index |
| pl_data | input | 32 | Preload data |
| rd_idx | input | 3 | Read port register index |
| rd_data | output | 32 | Registered read data |
| zero_flag | output | 1 | Comparison found a equal to b |
| neg_flag | output | 1 | Comparison found a below b |
| illegal_op | output | 1 | Last decoded instruction had a equal to c |

## Verification
The bench targets the sign-dependent ordering. This covers pairs of negatives, where a plain unsigned compare would pick the more negative value, and the -0 against +0 pair, where a design that treats the zeros as equal would set the zero flag and skip the move. It loads NaN and subnormal challengers of both signs. A missing or wrong cleaning step shows up as a stored payload or a negative zero. It also uses d equal to a, where a design that reads d after the write would copy the new maximum into c instead of the old value. Illegal, foreign-opcode and preload-during-instruction cycles are checked for silent register or flag corruption, and a long random phase compares every register and flag against a behavioural model.

// File: rtl/fmx_pkg.sv
package fmx_pkg;

  // Outcome of ordering operand a against operand b
  typedef enum logic [1:0] {
    CMP_GT = 2'b00,
    CMP_EQ = 2'b01,
    CMP_LT = 2'b10
  } cmp_e;

  localparam logic [15:0] DEF_OPCODE = 16'hE69C;

endpackage

// File: rtl/fmx_decode.sv
module fmx_decode #(
  parameter int IDX_W = 3,
  parameter int OPC_W = 16,
  parameter logic [OPC_W-1:0] OPCODE = 16'hE69C
) (
  input  logic               valid,
  input  logic [2*OPC_W-1:0] word,
  output logic               accept,
  output logic               illegal,
  output logic [IDX_W-1:0]   idx_a,
  output logic [IDX_W-1:0]   idx_b,
  output logic [IDX_W-1:0]   idx_c,
  output logic [IDX_W-1:0]   idx_d
);
  localparam int FLD_W = 4 * IDX_W;
  localparam int PAD_W = OPC_W - FLD_W;

  logic [OPC_W-1:0] hi_half;
  logic             pad_ok;
  logic             match;

  assign hi_half = word[2*OPC_W-1:OPC_W];

  generate
    if (PAD_W > 0) begin : g_pad
      assign pad_ok = (hi_half[OPC_W-1:FLD_W] == '0);
    end else begin : g_nopad
      assign pad_ok = 1'b1;
    end
  endgenerate

  assign idx_a = hi_half[IDX_W-1:0];
  assign idx_b = hi_half[2*IDX_W-1:IDX_W];
  assign idx_c = hi_half[3*IDX_W-1:2*IDX_W];
  assign idx_d = hi_half[4*IDX_W-1:3*IDX_W];

  assign match   = valid && pad_ok && (word[OPC_W-1:0] == OPCODE);
  assign accept  = match && (idx_a != idx_c);
  assign illegal = match && (idx_a == idx_c);

endmodule

// File: rtl/fmx_compare.sv
module fmx_compare import fmx_pkg::*; #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output cmp_e              res
);
  logic              sgn_a, sgn_b;
  logic [DATA_W-2:0] mag_a, mag_b;

  assign sgn_a = opa[DATA_W-1];
  assign sgn_b = opb[DATA_W-1];
  assign mag_a = opa[DATA_W-2:0];
  assign mag_b = opb[DATA_W-2:0];

  always_comb begin
    if (opa == opb) begin
      res = CMP_EQ;
    end else if (sgn_a != sgn_b) begin
      // the negative one is smaller, -0 included
      res = sgn_a ? CMP_LT : CMP_GT;
    end else if (!sgn_a) begin
      res = (mag_a < mag_b) ? CMP_LT : CMP_GT;
    end else begin
      // both negative: larger magnitude is the smaller value
      res = (mag_a > mag_b) ? CMP_LT : CMP_GT;
    end
  end

endmodule

// File: rtl/fmx_sanitize.sv
module fmx_sanitize #(
  parameter int DATA_W = 32,
  parameter int EXP_W  = 8
) (
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  localparam int MAN_W = DATA_W - 1 - EXP_W;

  logic [EXP_W-1:0] expo;
  logic [MAN_W-1:0] mant;
  logic             is_nan, is_sub;

  assign expo   = din[DATA_W-2 -: EXP_W];
  assign mant   = din[MAN_W-1:0];
  assign is_nan = (&expo) && (|mant);
  assign is_sub = (expo == '0) && (|mant);

  always_comb begin
    if (is_nan) begin
      dout = {din[DATA_W-1], {EXP_W{1'b1}}, {MAN_W{1'b0}}};
    end else if (is_sub) begin
      dout = '0;
    end else begin
      dout = din;
    end
  end

endmodule

// File: rtl/fmx_regbank.sv
module fmx_regbank #(
  parameter int NREG   = 8,
  parameter int DATA_W = 32,
  parameter int IDX_W  = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  ra_idx,
  input  logic [IDX_W-1:0]  rb_idx,
  input  logic [IDX_W-1:0]  rd_src_idx,
  output logic [DATA_W-1:0] ra_val,
  output logic [DATA_W-1:0] rb_val,
  output logic [DATA_W-1:0] rd_src_val,
  input  logic              wa_en,
  input  logic [IDX_W-1:0]  wa_idx,
  input  logic [DATA_W-1:0] wa_val,
  input  logic              wc_en,
  input  logic [IDX_W-1:0]  wc_idx,
  input  logic [DATA_W-1:0] wc_val,
  input  logic              wp_en,
  input  logic [IDX_W-1:0]  wp_idx,
  input  logic [DATA_W-1:0] wp_val,
  input  logic [IDX_W-1:0]  port_idx,
  output logic [DATA_W-1:0] port_val
);
  logic [DATA_W-1:0] regs [NREG];

  assign ra_val     = regs[ra_idx];
  assign rb_val     = regs[rb_idx];
  assign rd_src_val = regs[rd_src_idx];

  // Three write sources per entry; target indices a and c never match
  generate
    for (genvar gi = 0; gi < NREG; gi++) begin : g_entry
      always_ff @(posedge clk) begin
        if (rst) begin
          regs[gi] <= '0;
        end else if (wa_en && (wa_idx == IDX_W'(gi))) begin
          regs[gi] <= wa_val;
        end else if (wc_en && (wc_idx == IDX_W'(gi))) begin
          regs[gi] <= wc_val;
        end else if (wp_en && (wp_idx == IDX_W'(gi))) begin
          regs[gi] <= wp_val;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      port_val <= '0;
    end else begin
      port_val <= regs[port_idx];
    end
  end

endmodule

// File: rtl/fmax_move_unit.sv
module fmax_move_unit import fmx_pkg::*; #(
  parameter int NREG   = 8,
  parameter int DATA_W = 32,
  parameter int EXP_W  = 8,
  parameter int OPC_W  = 16,
  parameter logic [OPC_W-1:0] OPCODE = DEF_OPCODE,
  localparam int IDX_W  = $clog2(NREG),
  localparam int WORD_W = 2 * OPC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_valid,
  input  logic [WORD_W-1:0] instr_word,
  input  logic              pl_we,
  input  logic [IDX_W-1:0]  pl_idx,
  input  logic [DATA_W-1:0] pl_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              zero_flag,
  output logic              neg_flag,
  output logic              illegal_op
);
  logic              dec_ok, dec_bad;
  logic [IDX_W-1:0]  fa, fb, fc, fd;
  logic [DATA_W-1:0] va, vb, vd, vb_clean;
  cmp_e              order;
  logic              take_b;

  fmx_decode #(.IDX_W(IDX_W), .OPC_W(OPC_W), .OPCODE(OPCODE)) u_dec (
    .valid(instr_valid), .word(instr_word),
    .accept(dec_ok), .illegal(dec_bad),
    .idx_a(fa), .idx_b(fb), .idx_c(fc), .idx_d(fd)
  );

  fmx_regbank #(.NREG(NREG), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst(rst),
    .ra_idx(fa), .rb_idx(fb), .rd_src_idx(fd),
    .ra_val(va), .rb_val(vb), .rd_src_val(vd),
    .wa_en(take_b), .wa_idx(fa), .wa_val(vb_clean),
    .wc_en(take_b), .wc_idx(fc), .wc_val(vd),
    .wp_en(pl_we && !instr_valid), .wp_idx(pl_idx), .wp_val(pl_data),
    .port_idx(rd_idx), .port_val(rd_data)
  );

  fmx_compare #(.DATA_W(DATA_W)) u_cmp (
    .opa(va), .opb(vb), .res(order)
  );

  fmx_sanitize #(.DATA_W(DATA_W), .EXP_W(EXP_W)) u_san (
    .din(vb), .dout(vb_clean)
  );

  assign take_b = dec_ok && (order == CMP_LT);

  always_ff @(posedge clk) begin
    if (rst) begin
      zero_flag  <= 1'b0;
      neg_flag   <= 1'b0;
      illegal_op <= 1'b0;
    end else begin
      illegal_op <= dec_bad;
      if (dec_ok) begin
        zero_flag <= (order == CMP_EQ);
        neg_flag  <= (order == CMP_LT);
      end
    end
  end

endmodule

// File: rtl/fmx_chk.sv
module fmx_chk #(
  parameter int IDX_W  = 3,
  parameter int DATA_W = 32,
  parameter int OPC_W  = 16,
  parameter logic [OPC_W-1:0] OPCODE = 16'hE69C
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 instr_valid,
  input logic [2*OPC_W-1:0]   instr_word,
  input logic                 zero_flag,
  input logic                 neg_flag,
  input logic                 illegal_op
);
  localparam int FLD_W = 4 * IDX_W;

  logic             word_ok;
  logic [IDX_W-1:0] xa, xb, xc;

  assign word_ok = instr_valid && (instr_word[OPC_W-1:0] == OPCODE)
                   && (instr_word[2*OPC_W-1:OPC_W+FLD_W] == '0);
  assign xa = instr_word[OPC_W +: IDX_W];
  assign xb = instr_word[OPC_W+IDX_W +: IDX_W];
  assign xc = instr_word[OPC_W+2*IDX_W +: IDX_W];

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(zero_flag && neg_flag)); // R8

  AST_ILLEGAL_RAISES_ERR: assert property (@(posedge clk) disable iff (rst)
    (word_ok && xa == xc) |=> illegal_op); // R3

  AST_ILLEGAL_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (word_ok && xa == xc) |=> ($stable(zero_flag) && $stable(neg_flag))); // R3

  AST_SAME_SOURCE_EQUAL: assert property (@(posedge clk) disable iff (rst)
    (word_ok && xa == xb && xa != xc) |=> (zero_flag && !neg_flag)); // R8

  AST_FOREIGN_WORD_QUIET: assert property (@(posedge clk) disable iff (rst)
    !word_ok |=> (!illegal_op && $stable(zero_flag) && $stable(neg_flag))); // R2

endmodule

bind fmax_move_unit fmx_chk #(
  .IDX_W(IDX_W), .DATA_W(DATA_W), .OPC_W(OPC_W), .OPCODE(OPCODE)
) u_chk (
  .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
  .zero_flag(zero_flag), .neg_flag(neg_flag), .illegal_op(illegal_op)
);

// File: tb/fmax_move_unit_bench.sv
module fmax_move_unit_bench;
  localparam int CLK_P = 10;
  localparam logic [15:0] OPC = 16'hE69C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic [31:0] instr_word = '0;
  logic        pl_we = 1'b0;
  logic [2:0]  pl_idx = '0;
  logic [31:0] pl_data = '0;
  logic [2:0]  rd_idx = '0;
  logic [31:0] rd_data;
  logic        zero_flag, neg_flag, illegal_op;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference state
  logic [31:0] m [8];
  logic [31:0] m_rd;
  logic        m_zf, m_nf, m_err;

  fmax_move_unit u_fmax_move_unit (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
    .pl_we(pl_we), .pl_idx(pl_idx), .pl_data(pl_data),
    .rd_idx(rd_idx), .rd_data(rd_data),
    .zero_flag(zero_flag), .neg_flag(neg_flag), .illegal_op(illegal_op)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic bit below(logic [31:0] x, logic [31:0] y);
    if (x == y) return 0;
    if (x[31] != y[31]) return x[31];
    if (!x[31]) return x[30:0] < y[30:0];
    return x[30:0] > y[30:0];
  endfunction

  function automatic logic [31:0] clean(logic [31:0] v);
    if (v[30:23] == 8'hFF && v[22:0] != 0) return {v[31], 8'hFF, 23'd0};
    if (v[30:23] == 8'h00 && v[22:0] != 0) return 32'd0;
    return v;
  endfunction

  task automatic model_edge();
    logic [31:0] va, vb, vd;
    int a, b, c, d;
    if (rst) begin
      for (int i = 0; i < 8; i++) m[i] = '0;
      m_rd = '0; m_zf = 0; m_nf = 0; m_err = 0;
    end else begin
      m_rd = m[rd_idx];
      m_err = 0;
      if (instr_valid) begin
        if (instr_word[15:0] == OPC && instr_word[31:28] == 0) begin
          a = instr_word[18:16]; b = instr_word[21:19];
          c = instr_word[24:22]; d = instr_word[27:25];
          if (a == c) m_err = 1;
          else begin
            va = m[a]; vb = m[b]; vd = m[d];
            if (va == vb) begin m_zf = 1; m_nf = 0; end
            else if (below(va, vb)) begin
              m[a] = clean(vb); m[c] = vd; m_zf = 0; m_nf = 1;
            end else begin m_zf = 0; m_nf = 0; end
          end
        end
      end else if (pl_we) begin
        m[pl_idx] = pl_data;
      end
    end
  endtask

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(tag, "rd_data", rd_data, m_rd);
    chk(tag, "zero_flag", {31'd0, zero_flag}, {31'd0, m_zf});
    chk(tag, "neg_flag", {31'd0, neg_flag}, {31'd0, m_nf});
    chk(tag, "illegal_op", {31'd0, illegal_op}, {31'd0, m_err});
  endtask

  task automatic op(string tag, int a, int b, int c, int d,
                    logic [15:0] opc = OPC, logic [3:0] top = 4'd0);
    instr_valid = 1;
    instr_word = {top, d[2:0], c[2:0], b[2:0], a[2:0], opc};
    cyc(tag);
    instr_valid = 0;
    instr_word = '0;
  endtask

  task automatic preload(int i, logic [31:0] v);
    pl_we = 1; pl_idx = i[2:0]; pl_data = v;
    cyc("R9");
    pl_we = 0;
  endtask

  task automatic sweep(string tag);
    for (int i = 0; i < 8; i++) begin
      rd_idx = i[2:0];
      cyc(tag);
    end
  endtask

  // direct check of one register as it stands now (takes one cycle)
  task automatic expect_reg(string tag, int i, logic [31:0] v);
    rd_idx = i[2:0];
    cyc(tag);
    chk(tag, "register value", rd_data, v);
  endtask

  function automatic logic [31:0] pick_val();
    case ($urandom_range(0, 7))
      0: return {$urandom_range(0, 1) == 1, 8'hFF, 23'($urandom_range(1, 4095))};
      1: return {$urandom_range(0, 1) == 1, 8'h00, 23'($urandom_range(1, 4095))};
      2: return {$urandom_range(0, 1) == 1, 31'd0};
      3: return {$urandom_range(0, 1) == 1, 8'hFF, 23'd0};
      default: return $urandom();
    endcase
  endfunction

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog all-requirements actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) m[i] = 32'hDEAD_BEEF;
    m_rd = 'x; m_zf = 0; m_nf = 0; m_err = 0;
    // R1: reset
    rst = 1;
    cyc("R1");
    cyc("R1");
    rst = 0;
    sweep("R1");

    // R9 preloads
    preload(0, 32'h40A00000);   // 5.0
    preload(1, 32'h40800000);   // 4.0
    preload(2, 32'hBFC00000);   // -1.5
    preload(3, 32'hC0000000);   // -2.0
    preload(4, 32'h7FC00001);   // +NaN
    preload(5, 32'h00000123);   // +subnormal
    preload(6, 32'h80000000);   // -0
    preload(7, 32'hFF800001);   // -NaN
    sweep("R10");

    // R8 a above b: no write
    op("R8", 0, 1, 3, 2);
    expect_reg("R5", 0, 32'h40A00000);
    expect_reg("R5", 3, 32'hC0000000);
    // R5 a below b: move and copy
    op("R5", 1, 0, 3, 2);
    chk("R8", "neg_flag after lt", {31'd0, neg_flag}, 32'd1);
    expect_reg("R5", 1, 32'h40A00000);
    expect_reg("R5", 3, 32'hBFC00000);
    // R8 equal
    op("R8", 0, 1, 2, 1);
    chk("R8", "zero_flag on equal", {31'd0, zero_flag}, 32'd1);

    // R4 two negatives: -2.0 (r3 restored) vs -1.5
    preload(3, 32'hC0000000);
    op("R4", 3, 2, 0, 6);
    expect_reg("R4", 3, 32'hBFC00000);
    expect_reg("R4", 0, 32'h80000000);
    // R4 -0 vs +0
    preload(1, 32'h00000000);
    op("R4", 6, 1, 2, 3);
    chk("R4", "neg_flag -0 below +0", {31'd0, neg_flag}, 32'd1);
    expect_reg("R4", 6, 32'h00000000);

    // R6 NaN challengers, R7 subnormal challengers
    preload(0, 32'h3F800000);
    op("R6", 0, 4, 2, 0);            // +NaN beats 1.0; d==a: c gets old a
    expect_reg("R6", 0, 32'h7F800000);
    expect_reg("R5", 2, 32'h3F800000);
    preload(2, 32'hC1000000);        // -8.0
    op("R6", 2, 7, 1, 5);            // -NaN large magnitude? pattern below -8? no: checked by model
    preload(1, 32'h80000005);        // -subnormal
    op("R7", 1, 5, 3, 4);
    expect_reg("R7", 1, 32'h00000000);
    preload(1, 32'hC0400000);        // -3.0
    preload(5, 32'h80000007);        // -subnormal, above -3.0
    op("R7", 1, 5, 3, 4);
    expect_reg("R7", 1, 32'h00000000);

    // R3 illegal a==c
    preload(0, 32'hC2000000);
    op("R3", 0, 4, 0, 1);
    chk("R3", "illegal_op raised", {31'd0, illegal_op}, 32'd1);
    expect_reg("R3", 0, 32'hC2000000);
    // R2 foreign opcode and bad upper nibble
    op("R2", 0, 4, 2, 1, 16'hE69D);
    expect_reg("R2", 0, 32'hC2000000);
    op("R2", 0, 4, 2, 1, OPC, 4'h8);
    expect_reg("R2", 0, 32'hC2000000);
    // R9 preload ignored while instruction valid
    pl_we = 1; pl_idx = 3'd6; pl_data = 32'h12345678;
    op("R9", 0, 0, 2, 1);
    pl_we = 0;
    expect_reg("R9", 6, 32'h00000000);
    sweep("R10");

    // random phase
    for (int n = 0; n < 500; n++) begin
      rd_idx = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 3) == 0) begin
        pl_we = 1; pl_idx = 3'($urandom_range(0, 7)); pl_data = pick_val();
      end
      if ($urandom_range(0, 2) != 0) begin
        instr_valid = 1;
        instr_word = {($urandom_range(0, 15) == 0) ? 4'h1 : 4'h0,
                      12'($urandom()),
                      ($urandom_range(0, 15) == 0) ? 16'h1234 : OPC};
      end
      cyc("R5");
      instr_valid = 0; instr_word = '0; pl_we = 0;
    end
    sweep("R10");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule